// File: doc/BRIEF.md
# Chirp K-J sequence validator

During the high-speed detection handshake, a USB device must decide whether the port above it answers with an alternating train of chirp K and chirp J bus states. These chirps change far too slowly for the serial receive path to pick them up. This block therefore watches the raw two-bit UTMI line state and reaches the decision itself.

The line-state input carries no filtering. A bus state is taken into account only after it has been seen unchanged for a programmable number of consecutive clock samples. At 60 MHz the default of 150 samples equals 2.5 us. Accepted states drive a small sequencer that expects K and J in strict alternation and counts each accepted chirp. When the count reaches the target (six by default, the pattern K-J-K-J-K-J), the sequencer reports a valid result. If the bus settles to SE0 before then, it reports an invalid result. Both results are sticky. Dropping the enable input resets the whole block, and raising it again starts a fresh detection.

Top module: `chirp_kj_validator`

## Requirements
- R1: The line state is decoded as 2'b00 = SE0, 2'b01 = J, 2'b10 = K. The code 2'b11 is never accepted as a bus state and has no effect on the count or the results.
- R2: A line state is accepted only after it has been present on HOLD_CYCLES consecutive rising clock edges. Any change of value restarts the run. The count and results update on the edge that follows the last of those HOLD_CYCLES samples. A state held for HOLD_CYCLES-1 edges is ignored.
- R3: While enable is low, the count is 0 and both results are low. When enable rises, detection starts by waiting for a K.
- R4: While waiting for K, an accepted K increments the count and the block then waits for J. An accepted J is ignored.
- R5: While waiting for J, an accepted J increments the count and the block then waits for K. An accepted K is ignored.
- R6: When the count reaches CHIRP_TARGET, the valid result goes high and the count holds at CHIRP_TARGET. Valid is never high at any other count.
- R7: An accepted SE0 while waiting for K or J, with the count below CHIRP_TARGET, sets the invalid result.
- R8: Valid and invalid are never high together. Once either is set, it stays set and no later line state changes the count or the results until enable goes low.
- R9: The count changes by at most one per clock cycle while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Detection in progress; low holds the block cleared |
| line_state | input | 2 | Raw UTMI line state |
| chirp_count | output | $clog2(CHIRP_TARGET+1) | Number of accepted chirps |
| chirp_valid | output | 1 | Sticky: alternating sequence completed |
| chirp_invalid | output | 1 | Sticky: SE0 seen before the sequence completed |

## Verification
The bench builds the block with HOLD_CYCLES = 4 and CHIRP_TARGET = 6. With such a short hold, every sequence of seven accepted states drawn from K, J and SE0 fits in a few dozen cycles, so all 2187 of them are swept after a fresh enable. Segment lengths are mixed between one below, exactly at, and one above the hold limit, and the non-matching code is dropped in among them. Directed cases pin the exact edge on which an acceptance lands, the restart of the run when the value changes, and the clearing effect of enable.

// File: rtl/chirp_kj_pkg.sv
package chirp_kj_pkg;

    // Raw UTMI line-state codes
    typedef enum logic [1:0] {
        LS_SE0  = 2'b00,
        LS_J    = 2'b01,
        LS_K    = 2'b10,
        LS_NONE = 2'b11
    } line_t;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_WAIT_K = 2'd0,
        SEQ_WAIT_J = 2'd1,
        SEQ_GOOD   = 2'd2,
        SEQ_BAD    = 2'd3
    } seq_t;

endpackage

// File: rtl/chirp_line_filter.sv
module chirp_line_filter
    import chirp_kj_pkg::*;
#(
    parameter int HOLD_CYCLES = 150,
    localparam int RUN_W      = $clog2(HOLD_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] line_state,
    output logic       stable,
    output logic [1:0] stable_state
);

    typedef struct packed {
        logic [1:0]       samp;
        logic [RUN_W-1:0] run;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (!enable) begin
            flt_d.samp = LS_NONE;
            flt_d.run  = '0;
        end else begin
            flt_d.samp = line_state;
            if (line_state != flt_q.samp) begin
                flt_d.run = RUN_W'(1);
            end else if (flt_q.run != RUN_W'(HOLD_CYCLES)) begin
                flt_d.run = RUN_W'(flt_q.run + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q.samp <= LS_NONE;
            flt_q.run  <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    // A run that has reached the limit qualifies; the non-matching code never does
    assign stable       = enable && (flt_q.run == RUN_W'(HOLD_CYCLES))
                          && (flt_q.samp != LS_NONE);
    assign stable_state = flt_q.samp;

endmodule

// File: rtl/chirp_seq_tracker.sv
module chirp_seq_tracker
    import chirp_kj_pkg::*;
#(
    parameter int CHIRP_TARGET = 6,
    localparam int CNT_W       = $clog2(CHIRP_TARGET + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             stable,
    input  logic [1:0]       stable_state,
    output logic [CNT_W-1:0] count,
    output logic             good,
    output logic             bad
);

    typedef struct packed {
        seq_t             st;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (!enable) begin
            trk_d.st  = SEQ_WAIT_K;
            trk_d.cnt = '0;
        end else if (stable) begin
            unique case (trk_q.st)
                SEQ_WAIT_K: begin
                    if (stable_state == LS_K) begin
                        trk_d.cnt = CNT_W'(trk_q.cnt + 1'b1);
                        trk_d.st  = (trk_d.cnt == CNT_W'(CHIRP_TARGET)) ? SEQ_GOOD : SEQ_WAIT_J;
                    end else if (stable_state == LS_SE0) begin
                        trk_d.st = SEQ_BAD;
                    end
                end
                SEQ_WAIT_J: begin
                    if (stable_state == LS_J) begin
                        trk_d.cnt = CNT_W'(trk_q.cnt + 1'b1);
                        trk_d.st  = (trk_d.cnt == CNT_W'(CHIRP_TARGET)) ? SEQ_GOOD : SEQ_WAIT_K;
                    end else if (stable_state == LS_SE0) begin
                        trk_d.st = SEQ_BAD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.st  <= SEQ_WAIT_K;
            trk_q.cnt <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign count = trk_q.cnt;
    assign good  = (trk_q.st == SEQ_GOOD);
    assign bad   = (trk_q.st == SEQ_BAD);

endmodule

// File: rtl/chirp_kj_validator.sv
module chirp_kj_validator #(
    parameter int HOLD_CYCLES  = 150,
    parameter int CHIRP_TARGET = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                enable,
    input  logic [1:0]                          line_state,
    output logic [$clog2(CHIRP_TARGET+1)-1:0]   chirp_count,
    output logic                                chirp_valid,
    output logic                                chirp_invalid
);

    logic       flt_stable;
    logic [1:0] flt_state;

    chirp_line_filter #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .line_state   (line_state),
        .stable       (flt_stable),
        .stable_state (flt_state)
    );

    chirp_seq_tracker #(
        .CHIRP_TARGET (CHIRP_TARGET)
    ) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .stable       (flt_stable),
        .stable_state (flt_state),
        .count        (chirp_count),
        .good         (chirp_valid),
        .bad          (chirp_invalid)
    );

endmodule

// File: rtl/chirp_kj_validator_chk.sv
module chirp_kj_validator_chk #(
    parameter int CHIRP_TARGET = 6,
    localparam int CNT_W       = $clog2(CHIRP_TARGET + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [CNT_W-1:0] chirp_count,
    input logic             chirp_valid,
    input logic             chirp_invalid
);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(chirp_valid && chirp_invalid));

    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && chirp_valid) |=> chirp_valid);

    p_invalid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && chirp_invalid) |=> chirp_invalid);

    p_count_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (chirp_valid || chirp_invalid)) |=> $stable(chirp_count));

    p_disable_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (chirp_count == '0 && !chirp_valid && !chirp_invalid));

    p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> (chirp_count == $past(chirp_count)
                    || chirp_count == CNT_W'($past(chirp_count) + 1'b1)));

    p_valid_at_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_valid |-> chirp_count == CNT_W'(CHIRP_TARGET));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_count <= CNT_W'(CHIRP_TARGET));

    p_invalid_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_invalid |-> chirp_count < CNT_W'(CHIRP_TARGET));

endmodule

bind chirp_kj_validator chirp_kj_validator_chk #(
    .CHIRP_TARGET (CHIRP_TARGET)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .chirp_count   (chirp_count),
    .chirp_valid   (chirp_valid),
    .chirp_invalid (chirp_invalid)
);

// File: tb/chirp_kj_validator_test.sv
module chirp_kj_validator_test;

    localparam int H     = 4;
    localparam int T     = 6;
    localparam int CNT_W = $clog2(T + 1);

    localparam logic [1:0] V_SE0 = 2'b00;
    localparam logic [1:0] V_J   = 2'b01;
    localparam logic [1:0] V_K   = 2'b10;
    localparam logic [1:0] V_X   = 2'b11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [1:0]       line_state = V_X;
    logic [CNT_W-1:0] chirp_count;
    logic             chirp_valid;
    logic             chirp_invalid;

    int n_tests = 0;
    int n_fail  = 0;

    // expected model: 0 wait K, 1 wait J, 2 valid, 3 invalid
    int exp_st  = 0;
    int exp_cnt = 0;

    always #5 clk = ~clk;

    chirp_kj_validator #(
        .HOLD_CYCLES  (H),
        .CHIRP_TARGET (T)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .line_state    (line_state),
        .chirp_count   (chirp_count),
        .chirp_valid   (chirp_valid),
        .chirp_invalid (chirp_invalid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int packed_out();
        return (int'(chirp_count) << 2) | (int'(chirp_valid) << 1) | int'(chirp_invalid);
    endfunction

    function automatic int packed_exp();
        return (exp_cnt << 2) | ((exp_st == 2) ? 2 : 0) | ((exp_st == 3) ? 1 : 0);
    endfunction

    // called at a negedge; ends at a negedge
    task automatic restart();
        enable = 1'b0;
        line_state = V_X;
        @(negedge clk);
        @(negedge clk);
        exp_st = 0;
        exp_cnt = 0;
        check("R3 cleared while disabled", packed_out(), 0);
        enable = 1'b1;
    endtask

    // hold v for len edges, then one neutral edge, then compare with model
    task automatic seg(input logic [1:0] v, input int len);
        string tag;
        for (int i = 0; i < len; i++) begin
            line_state = v;
            @(negedge clk);
        end
        line_state = V_X;
        @(negedge clk);
        tag = "R2 short hold ignored";
        if (len >= H) begin
            if (v == V_X) tag = "R1 code 11 ignored";
            else if (exp_st >= 2) tag = "R8 result frozen";
            else if (v == V_SE0) begin
                tag = "R7 SE0 invalidates";
                exp_st = 3;
            end else if (exp_st == 0) begin
                tag = "R4 waiting for K";
                if (v == V_K) begin
                    exp_cnt++;
                    exp_st = (exp_cnt == T) ? 2 : 1;
                end
            end else begin
                tag = "R5 waiting for J";
                if (v == V_J) begin
                    exp_cnt++;
                    exp_st = (exp_cnt == T) ? 2 : 0;
                    if (exp_cnt == T) tag = "R6 target reached";
                end
            end
        end
        check(tag, packed_out(), packed_exp());
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3 reset state", packed_out(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 idle while disabled", packed_out(), 0);

        // R2: exact latency of acceptance
        restart();
        for (int i = 0; i < H; i++) begin
            line_state = V_K;
            @(negedge clk);
            check("R2 not yet accepted", int'(chirp_count), 0);
        end
        @(negedge clk);
        check("R2 accepted on next edge", int'(chirp_count), 1);

        // R2: value change restarts the run
        restart();
        for (int i = 0; i < H - 1; i++) begin line_state = V_K; @(negedge clk); end
        line_state = V_J; @(negedge clk);
        for (int i = 0; i < H - 1; i++) begin line_state = V_K; @(negedge clk); end
        line_state = V_X; @(negedge clk);
        @(negedge clk);
        check("R2 interrupted runs ignored", int'(chirp_count), 0);

        // R1: long 11 has no effect; R8: long states after valid have no effect
        restart();
        seg(V_X, 3 * H);
        seg(V_K, H); seg(V_J, H); seg(V_K, H);
        seg(V_J, H); seg(V_K, H); seg(V_J, H);
        check("R6 valid after K-J-K-J-K-J", int'(chirp_valid), 1);
        seg(V_SE0, 3 * H);
        seg(V_K, 2 * H);
        check("R8 valid sticky, invalid low", packed_out(), (T << 2) | 2);

        // R3: enable low mid-sequence clears
        restart();
        seg(V_K, H); seg(V_J, H);
        restart();
        seg(V_J, H);
        check("R3 new detection waits for K", int'(chirp_count), 0);

        // Exhaustive sweep of seven-segment sequences over K, J, SE0
        for (int code = 0; code < 2187; code++) begin
            int c;
            c = code;
            restart();
            for (int i = 0; i < 7; i++) begin
                logic [1:0] v;
                int dig;
                int len;
                dig = c % 3;
                c = c / 3;
                v = (dig == 0) ? V_K : (dig == 1) ? V_J : V_SE0;
                if ((code + i) % 11 == 0) v = V_X;
                len = ((code + i) % 5 == 0) ? H - 1 : H + ((code + i) % 2);
                seg(v, len);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule